// File: doc/BRIEF.md
# Pixel Clock Synthesizer Parameter Search

This block finds the multiplier and divider settings for a frequency synthesizer that produces a pixel clock. Both settings lie in the range 1 to 63. The caller supplies two values in the same units: the reference frequency and the wanted pixel rate. The caller then pulses `start`.

The engine tries every multiplier/divider pair. Multipliers are taken in descending order, from 63 down to 1. For each multiplier, every divider is tried in descending order, from 63 down to 1. Each candidate rate is `((v * fref) / 1000) / r`, where both divisions are integer divisions that truncate. The engine keeps the pair whose rate lies closest to the target.

When the sweep ends, the engine raises `done` and presents a packed control word. One iterative divider handles all of the work:

- once per multiplier, it performs the scale-by-1000 division;
- once per candidate, it performs the division by the divider value.

The divider resolves `STEP` quotient bits per cycle. As a result, the run time is fixed and does not depend on the operands.

Top module: `pll_param_search`

## Requirements
- R1: When `done` rises, the packed result identifies the pair (v, r) with 1 <= v, r <= 63 that gives the least absolute difference between the target and `((v*fref)/1000)/r`, with both divisions truncating. The search uses the fref and target values captured at the accepted start.
- R2: When several pairs give the same least difference, the result is the pair visited last in the sweep order. In that order v runs from 63 down to 1 in the outer loop, and r runs from 63 down to 1 in the inner loop.
- R3: `ctrl_word` carries (v-1) in bits [13:8] and (r-1) in bits [5:0]. Bits [7:6] are always zero.
- R4: After reset, `busy` and `done` are low. `ctrl_word` reads 0, because the empty best pair (0,0) is clamped to (1,1) before packing.
- R5: A `start` pulse that arrives while `busy` is high is ignored. Changes on `fref` and `target` during a search do not alter its result or its duration.
- R6: `done` stays high, and `ctrl_word` stays unchanged, until the next `start`. A `start` accepted while idle or done makes `busy` high and `done` low from the following cycle.
- R7: `done` rises exactly 4032*ITER clock cycles after the edge that accepts `start`, where ITER = ceil((W+8)/STEP).
- R8: `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a search when not busy |
| fref | input | W | Reference frequency, captured at start |
| target | input | W | Wanted pixel rate, captured at start |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid; held until the next start |
| ctrl_word | output | 14 | Packed {v-1, 2'b00, r-1} |

## Verification
The tie rule is the hardest behaviour to expose at the ports. A typical operand pair seldom leaves two candidates with exactly equal error, so a wrong comparison would go unnoticed. The bench therefore sets a target of zero with a reference of 1000. With that stimulus, every pair with v < r gives a rate of zero. Only the last-visited pair (1,2) is then correct. A second stimulus, with an all-ones target, forces the single largest-rate pair (63,1). This drives the packed fields to their extremes. The bench also changes the inputs and repeats `start` in the middle of a search, to show that the captured operands and the fixed latency are unaffected.

// File: rtl/pll_param_search.sv
module pll_param_search #(
  parameter int W    = 32,
  parameter int STEP = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] fref,
  input  logic [W-1:0] target,
  output logic         busy,
  output logic         done,
  output logic [13:0]  ctrl_word
);
  localparam int NW   = W + 8;
  localparam int ITER = (NW + STEP - 1) / STEP;
  localparam int PW   = ITER * STEP;
  localparam int CW   = $clog2(ITER + 1);

  typedef enum logic [1:0] {S_IDLE, S_SCALE, S_RATIO, S_DONE} st_t;

  st_t           st;
  logic [5:0]    v_idx, r_idx, best_v, best_r;
  logic [W-1:0]  best_err, fref_q, tgt_q, q1k;
  logic [PW-1:0] shreg, sh_n;
  logic [10:0]   rem, rm_n;
  logic [9:0]    dvs;
  logic [CW-1:0] cnt;

  assign busy = (st == S_SCALE) || (st == S_RATIO);
  assign done = (st == S_DONE);

  always_comb begin
    sh_n = shreg;
    rm_n = rem;
    for (int i = 0; i < STEP; i++) begin
      rm_n = {rm_n[9:0], sh_n[PW-1]};
      sh_n = {sh_n[PW-2:0], 1'b0};
      if (rm_n >= {1'b0, dvs}) begin
        rm_n  = rm_n - {1'b0, dvs};
        sh_n[0] = 1'b1;
      end
    end
  end

  wire [W-1:0]  quo   = sh_n[W-1:0];
  wire [W-1:0]  err   = (quo >= tgt_q) ? quo - tgt_q : tgt_q - quo;
  wire          last  = (cnt == CW'(ITER - 1));
  wire [5:0]    vsel  = (st == S_RATIO) ? v_idx - 6'd1 : 6'd63;
  wire [W-1:0]  fsel  = (st == S_RATIO) ? fref_q : fref;
  wire [NW-1:0] prod  = NW'(fsel) * NW'(vsel);

  wire [5:0] v_cl = (best_v == 6'd0) ? 6'd1 : best_v;
  wire [5:0] r_cl = (best_r == 6'd0) ? 6'd1 : best_r;
  assign ctrl_word = {v_cl - 6'd1, 2'b00, r_cl - 6'd1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      v_idx    <= '0;
      r_idx    <= '0;
      best_v   <= '0;
      best_r   <= '0;
      best_err <= '1;
      fref_q   <= '0;
      tgt_q    <= '0;
      q1k      <= '0;
      shreg    <= '0;
      rem      <= '0;
      dvs      <= 10'd1000;
      cnt      <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          fref_q   <= fref;
          tgt_q    <= target;
          v_idx    <= 6'd63;
          r_idx    <= 6'd63;
          best_err <= '1;
          best_v   <= '0;
          best_r   <= '0;
          shreg    <= PW'(prod);
          rem      <= '0;
          dvs      <= 10'd1000;
          cnt      <= '0;
          st       <= S_SCALE;
        end
        S_SCALE: begin
          shreg <= sh_n;
          rem   <= rm_n;
          cnt   <= cnt + 1'b1;
          if (last) begin
            q1k   <= quo;
            shreg <= PW'(quo);
            rem   <= '0;
            dvs   <= {4'b0, r_idx};
            cnt   <= '0;
            st    <= S_RATIO;
          end
        end
        S_RATIO: begin
          shreg <= sh_n;
          rem   <= rm_n;
          cnt   <= cnt + 1'b1;
          if (last) begin
            if (err <= best_err) begin
              best_err <= err;
              best_v   <= v_idx;
              best_r   <= r_idx;
            end
            cnt <= '0;
            rem <= '0;
            if (r_idx == 6'd1) begin
              if (v_idx == 6'd1) begin
                st <= S_DONE;
              end else begin
                v_idx <= v_idx - 6'd1;
                r_idx <= 6'd63;
                shreg <= PW'(prod);
                dvs   <= 10'd1000;
                st    <= S_SCALE;
              end
            end else begin
              r_idx <= r_idx - 6'd1;
              shreg <= PW'(q1k);
              dvs   <= {4'b0, r_idx - 6'd1};
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(ctrl_word)));
  // R6
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));
  // R5
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && start) |=> ($stable(fref_q) && $stable(tgt_q)));
  // R1
  index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (v_idx != 6'd0 && r_idx != 6'd0 && dvs != 10'd0));
endmodule

// File: tb/pll_param_search_bench.sv
module pll_param_search_bench;
  localparam int W    = 32;
  localparam int STEP = 8;
  localparam int ITER = (W + 8 + STEP - 1) / STEP;
  localparam int LAT  = 4032 * ITER;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] fref = '0;
  logic [W-1:0] target = '0;
  logic         busy, done;
  logic [13:0]  ctrl_word;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pll_param_search #(.W(W), .STEP(STEP)) u_pll_param_search (
    .clk(clk), .rst_n(rst_n), .start(start), .fref(fref), .target(target),
    .busy(busy), .done(done), .ctrl_word(ctrl_word)
  );

  function automatic logic [13:0] ref_word(longint unsigned f, longint unsigned t);
    longint unsigned best = 64'hFFFF_FFFF;
    int bv = 0, br = 0;
    for (int v = 63; v > 0; v--)
      for (int r = 63; r > 0; r--) begin
        longint unsigned c = ((longint'(v) * f) / 1000) / longint'(r);
        longint unsigned e = (c >= t) ? c - t : t - c;
        if (e <= best) begin best = e; bv = v; br = r; end
      end
    return {6'(bv - 1), 2'b00, 6'(br - 1)};
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(logic [W-1:0] f, logic [W-1:0] t);
    @(negedge clk);
    fref = f; target = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < LAT + 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    chk("R4 busy", busy, 0);
    chk("R4 done", done, 0);
    chk("R4 word", ctrl_word, 0);
  endtask

  task automatic t_typical;
    int n;
    launch(32'd24000, 32'd25175);
    chk("R6 busy after start", busy, 1);
    wait_done(n);
    chk("R7 latency", n, LAT);
    chk("R1 typical", ctrl_word, ref_word(24000, 25175));
    chk("R3 rsvd bits", ctrl_word[7:6], 0);
  endtask

  task automatic t_tie;
    int n;
    launch(32'd1000, 32'd0);
    wait_done(n);
    chk("R2 tie pair (1,2)", ctrl_word, 14'h0001);
    chk("R2 tie model", ctrl_word, ref_word(1000, 0));
  endtask

  task automatic t_max;
    int n;
    launch(32'd1000, 32'hFFFF_FFFF);
    wait_done(n);
    chk("R3 packing (63,1)", ctrl_word, 14'h3E00);
    chk("R8 not busy at done", busy, 0);
  endtask

  task automatic t_busy_ignore;
    int n;
    launch(32'd48000, 32'd65000);
    repeat (100) @(negedge clk);
    fref = 32'd7; target = 32'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    chk("R5 latency unchanged", n + 101, LAT);
    chk("R5 result from captured inputs", ctrl_word, ref_word(48000, 65000));
  endtask

  task automatic t_hold;
    int n;
    logic [13:0] w;
    w = ctrl_word;
    repeat (50) @(negedge clk);
    chk("R6 done held", done, 1);
    chk("R6 word held", ctrl_word, w);
    launch(32'd100000, 32'd108000);
    chk("R6 done cleared", done, 0);
    wait_done(n);
    chk("R1 restart result", ctrl_word, ref_word(100000, 108000));
    chk("R7 restart latency", n, LAT);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_typical;
    t_tie;
    t_max;
    t_busy_ignore;
    t_hold;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule